// File: doc/BRIEF.md
# Configurable Multi-Polynomial CRC Engine

This block computes a cyclic redundancy check over data that software writes into it through a small register port. A packed control word selects one of four generator polynomials: CCITT 16-bit, 8-bit, 16-bit and 32-bit. It also selects how many bytes each data write carries (one, two or four). Separate flags turn on bit reversal and one's complement for the incoming data and for the checksum that is read back. The same engine can therefore produce both MSB-first and reflected variants of the common CRCs without any software bit manipulation.

Software programs a seed value and then sets the engine-reset bit in the control word. That bit loads the running remainder from the seed and clears itself. Each later write to the data register folds the selected bytes into the remainder in one clock cycle, lowest byte first. After each fold a completion flag is raised. The flag drives the interrupt line when its enable bit is set, and it is cleared by writing a one to it. A plain valid/write register port stands in for a system bus. Reads are combinational.

Top module: `crc_engine`

## Requirements
- R1: After reset, every register (control, seed, checksum, interrupt enable, interrupt status) reads zero and `irq` is low.
- R2: Control bits 31:30 pick the generator: 00 is 0x1021 (16-bit), 01 is 0x07 (8-bit), 10 is 0x8005 (16-bit), 11 is 0x04C11DB7 (32-bit). The remainder is shifted MSB first, and the checksum is masked to the width of the mode.
- R3: Control bits 29:28 pick the bytes per data write: 00 takes byte 0 only, 01 takes bytes 0 then 1, 10 takes bytes 0 to 3 in ascending order. The code 11 behaves like 10. A change to this field or to the mode without the engine-reset bit keeps the running remainder.
- R4: Control bit 24 reverses the bit order inside each byte of the written data, and bit 26 complements the data. Both apply before the fold, with the complement taken after the reversal.
- R5: Control bit 25 reverses the checksum across the width of the mode, and bit 27 complements it within that width, after any reversal.
- R6: The seed register (offset 1) reads back what was written to it. Writing the control word with bit 0 set loads the remainder from the seed one cycle later, and bit 0 then reads back as zero.
- R7: A data write made in the cycle right after the engine-reset write is folded onto the seed, not onto the old remainder.
- R8: Interrupt status bit 0 (offset 5) is set by every data write and cleared only by writing 1 to it. `irq` is high exactly when that bit and enable bit 0 (offset 4) are both set.
- R9: The checksum register (offset 3) reflects a data write (offset 2) in the first read after that write.
- R10: In 8-bit and 16-bit write modes, the unused upper bytes of the data word have no effect on the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset: 0 control, 1 seed, 2 data, 3 checksum, 4 interrupt enable, 5 interrupt status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on the address |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume at most one register access per cycle. They also assume that the control word is not rewritten in the cycle the engine-reset bit is pending, unless that write is the one under test. The stimulus keeps to this by issuing every access as a single-cycle pulse from one driver. It places the data write of the seed-collision case directly after the reset write, so no other access falls between them. Expected checksums come from a bit-serial reference and from published check values of the string "123456789".

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int CRC_W = 32;

  typedef enum logic [1:0] {
    POLY_CCITT = 2'b00,
    POLY_C8    = 2'b01,
    POLY_C16   = 2'b10,
    POLY_C32   = 2'b11
  } poly_sel_e;

  typedef enum logic [1:0] {
    WID_8   = 2'b00,
    WID_16  = 2'b01,
    WID_32  = 2'b10,
    WID_RSV = 2'b11
  } wr_width_e;

  // control word layout; bit positions are software-visible
  typedef struct packed {
    poly_sel_e mode;     // 31:30
    wr_width_e wid;      // 29:28
    logic      out_inv;  // 27
    logic      in_inv;   // 26
    logic      out_rev;  // 25
    logic      in_rev;   // 24
    logic [22:0] spare;  // 23:1
    logic      eng_rst;  // 0
  } ctl_t;

  function automatic logic [5:0] mode_bits(poly_sel_e m);
    case (m)
      POLY_C8:  mode_bits = 6'd8;
      POLY_C32: mode_bits = 6'd32;
      default:  mode_bits = 6'd16;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] mode_poly(poly_sel_e m);
    case (m)
      POLY_CCITT: mode_poly = 32'h0000_1021;
      POLY_C8:    mode_poly = 32'h0000_0007;
      POLY_C16:   mode_poly = 32'h0000_8005;
      default:    mode_poly = 32'h04C1_1DB7;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] mode_mask(poly_sel_e m);
    case (m)
      POLY_C8:  mode_mask = 32'h0000_00FF;
      POLY_C32: mode_mask = 32'hFFFF_FFFF;
      default:  mode_mask = 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [7:0] rev8(logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  function automatic logic [CRC_W-1:0] rev_full(logic [CRC_W-1:0] v);
    for (int i = 0; i < CRC_W; i++) rev_full[i] = v[CRC_W-1-i];
  endfunction

  // one byte into a remainder held left-aligned in CRC_W bits
  function automatic logic [CRC_W-1:0] byte_step(logic [CRC_W-1:0] r_al,
                                                 logic [7:0] b,
                                                 logic [CRC_W-1:0] p_al);
    logic [CRC_W-1:0] r;
    r = r_al ^ {b, {(CRC_W-8){1'b0}}};
    for (int i = 0; i < 8; i++) begin
      if (r[CRC_W-1]) r = (r << 1) ^ p_al;
      else            r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_in_cond.sv
module crc_in_cond
  import crc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic              in_rev,
  input  logic              in_inv,
  output logic [DATA_W-1:0] dout
);
  localparam int BYTES = DATA_W / 8;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] lane;
    logic [7:0] lane_r;
    assign lane   = din[8*g +: 8];
    assign lane_r = in_rev ? rev8(lane) : lane;
    // complement is taken on the already reordered lane
    assign dout[8*g +: 8] = lane_r ^ {8{in_inv}};
  end
endmodule

// File: rtl/crc_fold.sv
module crc_fold
  import crc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [CRC_W-1:0]  rem_in,
  input  logic [DATA_W-1:0] din,
  input  poly_sel_e         mode,
  input  wr_width_e         wid,
  output logic [CRC_W-1:0]  rem_out
);
  localparam int BYTES = DATA_W / 8;
  localparam int CNT_W = $clog2(BYTES + 1);

  logic [5:0]       sh;
  logic [CRC_W-1:0] poly_al;
  logic [CNT_W-1:0] used;
  logic [CRC_W-1:0] stage [0:BYTES];

  always_comb begin
    sh      = 6'(CRC_W) - mode_bits(mode);
    poly_al = mode_poly(mode) << sh;
    case (wid)
      WID_8:   used = CNT_W'(1);
      WID_16:  used = CNT_W'(2);
      default: used = CNT_W'(BYTES);
    endcase
  end

  assign stage[0] = (rem_in & mode_mask(mode)) << sh;

  // byte lanes in ascending order; unused lanes pass the remainder through
  for (genvar g = 0; g < BYTES; g++) begin : g_step
    assign stage[g+1] = (CNT_W'(g) < used) ? byte_step(stage[g], din[8*g +: 8], poly_al)
                                           : stage[g];
  end

  assign rem_out = stage[BYTES] >> sh;
endmodule

// File: rtl/crc_out_cond.sv
module crc_out_cond
  import crc_pkg::*;
(
  input  logic [CRC_W-1:0] rem,
  input  poly_sel_e        mode,
  input  logic             out_rev,
  input  logic             out_inv,
  output logic [CRC_W-1:0] sum
);
  logic [5:0]       sh;
  logic [CRC_W-1:0] mask;
  logic [CRC_W-1:0] ordered;

  always_comb begin
    sh      = 6'(CRC_W) - mode_bits(mode);
    mask    = mode_mask(mode);
    ordered = out_rev ? (rev_full(rem) >> sh) : rem;
    sum     = (ordered & mask) ^ (out_inv ? mask : '0);
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(5);

  ctl_t             ctl_q, ctl_d;
  logic [CRC_W-1:0] seed_q, seed_d;
  logic [CRC_W-1:0] rem_q, rem_d;
  logic             ien_q, ien_d;
  logic             sts_q, sts_d;

  logic ctl_wr, seed_wr, data_wr, ien_wr, sts_wr;
  logic [CRC_W-1:0]  fold_base;
  logic [CRC_W-1:0]  fold_res;
  logic [DATA_W-1:0] data_c;
  logic [CRC_W-1:0]  sum;

  // write decode
  always_comb begin
    ctl_wr  = bus_valid && bus_write && (bus_addr == A_CTL);
    seed_wr = bus_valid && bus_write && (bus_addr == A_SEED);
    data_wr = bus_valid && bus_write && (bus_addr == A_DATA);
    ien_wr  = bus_valid && bus_write && (bus_addr == A_IEN);
    sts_wr  = bus_valid && bus_write && (bus_addr == A_STS);
  end

  // a pending engine reset makes the seed the base of a same-cycle fold
  assign fold_base = ctl_q.eng_rst ? seed_q : rem_q;

  crc_in_cond #(.DATA_W(DATA_W)) i_in_cond (
    .din    (bus_wdata),
    .in_rev (ctl_q.in_rev),
    .in_inv (ctl_q.in_inv),
    .dout   (data_c)
  );

  crc_fold #(.DATA_W(DATA_W)) i_fold (
    .rem_in  (fold_base),
    .din     (data_c),
    .mode    (ctl_q.mode),
    .wid     (ctl_q.wid),
    .rem_out (fold_res)
  );

  crc_out_cond i_out_cond (
    .rem     (rem_q),
    .mode    (ctl_q.mode),
    .out_rev (ctl_q.out_rev),
    .out_inv (ctl_q.out_inv),
    .sum     (sum)
  );

  // next state
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr)             ctl_d = ctl_t'(bus_wdata);
    else if (ctl_q.eng_rst) ctl_d.eng_rst = 1'b0;

    seed_d = seed_wr ? bus_wdata : seed_q;

    rem_d = rem_q;
    if (data_wr)            rem_d = fold_res;
    else if (ctl_q.eng_rst) rem_d = seed_q;

    ien_d = ien_wr ? bus_wdata[0] : ien_q;

    sts_d = sts_q;
    if (sts_wr && bus_wdata[0]) sts_d = 1'b0;
    if (data_wr)                sts_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      seed_q <= '0;
      rem_q  <= '0;
      ien_q  <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      seed_q <= seed_d;
      rem_q  <= rem_d;
      ien_q  <= ien_d;
      sts_q  <= sts_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL:   bus_rdata = DATA_W'(ctl_q);
      A_SEED:  bus_rdata = seed_q;
      A_SUM:   bus_rdata = sum;
      A_IEN:   bus_rdata = DATA_W'(ien_q);
      A_STS:   bus_rdata = DATA_W'(sts_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq = sts_q & ien_q;
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic        data_wr,
  input logic        ien_wr,
  input logic        rst_pend,
  input logic [31:0] seed_q,
  input logic [31:0] rem_q,
  input logic        sts,
  input logic        ien,
  input logic        irq
);
  // R6
  eng_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend && !ctl_wr |=> !rst_pend);

  // R6
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend && !data_wr |=> rem_q == $past(seed_q));

  // R8
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> sts);

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && ien && !ien_wr |=> irq);

  // R9
  rem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr && !rst_pend |=> $stable(rem_q));
endmodule

bind crc_engine crc_engine_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_wr   (ctl_wr),
  .data_wr  (data_wr),
  .ien_wr   (ien_wr),
  .rst_pend (ctl_q.eng_rst),
  .seed_q   (seed_q),
  .rem_q    (rem_q),
  .sts      (sts_q),
  .ien      (ien_q),
  .irq      (irq)
);

// File: tb/test_crc_engine.sv
module test_crc_engine;
  localparam int A_CTL = 0, A_SEED = 1, A_DATA = 2, A_SUM = 3, A_IEN = 4, A_STS = 5;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  // reference state
  logic [31:0] m_ctl, m_seed, m_rem;

  crc_engine i_crc_engine (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model (bit serial) ----------------
  function automatic int m_w(logic [1:0] m);
    return (m == 2'b01) ? 8 : (m == 2'b11) ? 32 : 16;
  endfunction
  function automatic logic [31:0] m_poly(logic [1:0] m);
    case (m)
      2'b00: return 32'h1021;
      2'b01: return 32'h07;
      2'b10: return 32'h8005;
      default: return 32'h04C11DB7;
    endcase
  endfunction
  function automatic logic [31:0] m_mask(logic [1:0] m);
    return (m_w(m) == 32) ? 32'hFFFF_FFFF : ((32'd1 << m_w(m)) - 1);
  endfunction

  function automatic logic [31:0] m_fold(logic [31:0] rem, logic [31:0] d, logic [31:0] c);
    int w = m_w(c[31:30]);
    int n = (c[29:28] == 2'b00) ? 1 : (c[29:28] == 2'b01) ? 2 : 4;
    logic [31:0] r = rem & m_mask(c[31:30]);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = d[8*k +: 8];
      logic [7:0] t;
      if (c[24]) begin
        for (int i = 0; i < 8; i++) t[i] = b[7-i];
        b = t;
      end
      if (c[26]) b = ~b;
      for (int i = 7; i >= 0; i--) begin
        logic fb = r[w-1] ^ b[i];
        r = (r << 1) & m_mask(c[31:30]);
        if (fb) r = r ^ m_poly(c[31:30]);
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] m_sum();
    int w = m_w(m_ctl[31:30]);
    logic [31:0] r = m_rem & m_mask(m_ctl[31:30]);
    logic [31:0] t = '0;
    if (m_ctl[25]) begin
      for (int i = 0; i < w; i++) t[i] = r[w-1-i];
      r = t;
    end
    if (m_ctl[27]) r = r ^ m_mask(m_ctl[31:30]);
    return r;
  endfunction

  function automatic logic [31:0] cw(logic [1:0] mode, logic [1:0] wid, bit oinv, bit iinv,
                                     bit orev, bit irev, bit rst);
    return {mode, wid, oinv, iinv, orev, irev, 23'd0, rst};
  endfunction

  // ---------------- driver ----------------
  task automatic bus_wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(posedge clk); #2;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(int a, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'(a);
    @(posedge clk); #2;
    bus_valid = 1'b0;
  endtask

  task automatic set_ctl(logic [31:0] d);
    bus_wr(A_CTL, d);
    m_ctl = d;
    if (d[0]) m_rem = m_seed;
    m_ctl[0] = 1'b0;
  endtask

  task automatic set_seed(logic [31:0] d);
    bus_wr(A_SEED, d);
    m_seed = d;
  endtask

  task automatic put(logic [31:0] d);
    bus_wr(A_DATA, d);
    m_rem = m_fold(m_rem, d, m_ctl);
  endtask

  task automatic put_str9();
    for (int i = 0; i < 9; i++) put(32'h31 + i);
  endtask

  task automatic chk_irq(logic e, string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  always begin
    @(posedge clk);
    #1;
    if (rst_n && bus_valid && !bus_write && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_ctl = '0; m_seed = '0; m_rem = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(A_CTL, 32'h0, "R1 control");
    bus_rd(A_SEED, 32'h0, "R1 seed");
    bus_rd(A_SUM, 32'h0, "R1 checksum");
    bus_rd(A_IEN, 32'h0, "R1 enable");
    bus_rd(A_STS, 32'h0, "R1 status");
    chk_irq(1'b0, "R1 irq");

    // R2 known answers, byte writes
    set_seed(32'hFFFF);
    set_ctl(cw(2'b00, 2'b00, 0, 0, 0, 0, 1));
    put_str9();
    bus_rd(A_SUM, 32'h29B1, "R2 ccitt check");

    set_seed(32'h0);
    set_ctl(cw(2'b01, 2'b00, 0, 0, 0, 0, 1));
    put_str9();
    bus_rd(A_SUM, 32'hF4, "R2 crc8 check");

    // R3 16-bit writes then a final byte, remainder kept across the width change
    set_ctl(cw(2'b10, 2'b01, 0, 0, 0, 0, 1));
    put(32'h3231); put(32'h3433); put(32'h3635); put(32'h3837);
    set_ctl(cw(2'b10, 2'b00, 0, 0, 0, 0, 0));
    put(32'h39);
    bus_rd(A_SUM, 32'hFEE8, "R3 crc16 halfword writes");

    // R3 32-bit writes
    set_seed(32'hFFFF_FFFF);
    set_ctl(cw(2'b11, 2'b10, 0, 0, 0, 0, 1));
    put(32'h3433_3231); put(32'h3837_3635);
    set_ctl(cw(2'b11, 2'b00, 0, 0, 0, 0, 0));
    put(32'h39);
    bus_rd(A_SUM, 32'h0376_E6E7, "R3 crc32 word writes");

    // R4 R5 reflected variant with final complement
    set_ctl(cw(2'b11, 2'b10, 1, 0, 1, 1, 1));
    put(32'h3433_3231); put(32'h3837_3635);
    set_ctl(cw(2'b11, 2'b00, 1, 0, 1, 1, 0));
    put(32'h39);
    bus_rd(A_SUM, 32'hCBF4_3926, "R4 R5 reflected crc32");

    // R4 input complement, and reversal with complement
    set_seed(32'h1234);
    set_ctl(cw(2'b10, 2'b10, 0, 1, 0, 0, 1));
    put(32'hA5C3_0F11);
    bus_rd(A_SUM, m_sum(), "R4 input complement");
    set_ctl(cw(2'b00, 2'b01, 0, 1, 0, 1, 1));
    put(32'h0000_80F0);
    bus_rd(A_SUM, m_sum(), "R4 input reverse then complement");

    // R5 output options on their own
    set_ctl(cw(2'b00, 2'b00, 0, 0, 1, 0, 1));
    put(32'h55);
    bus_rd(A_SUM, m_sum(), "R5 output reverse ccitt");
    set_ctl(cw(2'b01, 2'b00, 1, 0, 0, 0, 1));
    put(32'h55);
    bus_rd(A_SUM, m_sum(), "R5 output complement crc8");

    // R10 upper bytes ignored
    set_seed(32'h0);
    set_ctl(cw(2'b11, 2'b00, 0, 0, 0, 0, 1));
    put(32'hABCD_EF31);
    bus_rd(A_SUM, m_fold(32'h0, 32'h31, m_ctl), "R10 byte mode upper bytes");
    set_ctl(cw(2'b10, 2'b01, 0, 0, 0, 0, 1));
    put(32'hFFFF_3132);
    bus_rd(A_SUM, m_fold(32'h0, 32'h3132, m_ctl), "R10 halfword mode upper bytes");

    // R3 reserved width code acts as four bytes
    set_ctl(cw(2'b11, 2'b11, 0, 0, 0, 0, 1));
    put(32'hDEAD_BEEF);
    bus_rd(A_SUM, m_fold(32'h0, 32'hDEAD_BEEF, cw(2'b11, 2'b10, 0, 0, 0, 0, 0)),
           "R3 reserved width");

    // R6 seed readback, self-clearing reset bit, seed load
    set_seed(32'hC0FF_EE11);
    bus_rd(A_SEED, 32'hC0FF_EE11, "R6 seed readback");
    set_ctl(cw(2'b11, 2'b10, 0, 0, 0, 0, 1));
    bus_rd(A_CTL, cw(2'b11, 2'b10, 0, 0, 0, 0, 0), "R6 reset bit self clear");
    bus_rd(A_SUM, 32'hC0FF_EE11, "R6 remainder from seed");

    // R7 data write in the cycle after the reset write folds onto the seed
    put(32'h0BAD_F00D);
    set_ctl(cw(2'b11, 2'b10, 0, 0, 0, 0, 1));
    put(32'h1234_5678);
    bus_rd(A_SUM, m_fold(32'hC0FF_EE11, 32'h1234_5678, m_ctl), "R7 fold onto seed");

    // R9 single-cycle update, back to back
    put(32'h0000_0001);
    bus_rd(A_SUM, m_sum(), "R9 read after write");

    // R8 interrupt status and enable
    bus_wr(A_STS, 32'h1);
    bus_rd(A_STS, 32'h0, "R8 status cleared by one");
    put(32'h77);
    bus_rd(A_STS, 32'h1, "R8 status set by data write");
    chk_irq(1'b0, "R8 masked");
    bus_wr(A_STS, 32'h0);
    bus_rd(A_STS, 32'h1, "R8 zero write keeps status");
    bus_wr(A_IEN, 32'h1);
    chk_irq(1'b1, "R8 enabled");
    bus_wr(A_STS, 32'h1);
    chk_irq(1'b0, "R8 cleared");
    put(32'h78);
    chk_irq(1'b1, "R8 raised by write");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule